// File: doc/BRIEF.md
# Interrupt Request Queueing Controller

This block drives a single shared interrupt request line toward a host bus. Several interrupt sources share that line, and their edge events arrive here already merged into one pulse input. Service routines on the host acknowledge the request by writing a register, which reaches this block as a one-cycle clear strobe. A plain set/clear latch loses an event that arrives while a routine is still running and is about to issue its clear. This controller keeps such events and raises the line again later, so that no event is dropped.

The controller has three states. In `IDLE` the line is low. In `WAIT` the line is high and a countdown runs while the block waits for a clear. In `QUEUED` the line is low because an event arrived during service, and a countdown runs before the line is raised again. The transitions are:
- `IDLE→WAIT` on an event.
- `WAIT→IDLE` on a clear or when the count runs out.
- `WAIT→QUEUED` on an event.
- `QUEUED→QUEUED`, a retrigger, on an event.
- `QUEUED→WAIT` when the count runs out.

Every entry into `WAIT` or `QUEUED`, and every retrigger, loads the countdown from the `timeout_cycles` input. That value must be longer than the longest time any handler takes from entry to its clear write.

Top module: `irq_requeue_top`

## Requirements
- R1: A synchronous active-high `rst` puts the block in `IDLE`, and `irq_req` reads 0 on the clock after reset is sampled. This also holds when reset arrives during service.
- R2: In `IDLE`, an `evt_pulse` sampled at a clock edge makes `irq_req` read 1 after that edge (`IDLE→WAIT`).
- R3: In `WAIT`, with no event and no clear, `irq_req` stays 1 for exactly `timeout_cycles`+1 clocks and then returns to 0 (`WAIT→IDLE`, expiry). A value of 0 gives a one-clock pulse. The line then stays 0 until a new event.
- R4: In `WAIT`, a `clr_strobe` without an event makes `irq_req` read 0 after that edge (`WAIT→IDLE`, clear). The line stays 0 afterwards.
- R5: In `WAIT`, an event makes `irq_req` read 0 after that edge (`WAIT→QUEUED`). This includes an event on the last clock of the window.
- R6: In `QUEUED` with no further event, `irq_req` stays 0 for exactly `timeout_cycles`+1 clocks. It then reads 1 for a fresh window of `timeout_cycles`+1 clocks (`QUEUED→WAIT`).
- R7: In `QUEUED`, an event restarts the countdown (`QUEUED→QUEUED`). `irq_req` then stays 0 for `timeout_cycles`+1 clocks counted from that event, and this includes a retrigger on the last low clock.
- R8: An event and a clear in the same cycle act as the event alone: `IDLE→WAIT` and `WAIT→QUEUED`.
- R9: A clear strobe in `IDLE` or in `QUEUED` has no effect. In `IDLE` the line stays 0, and in `QUEUED` the re-raise still comes at the scheduled clock.
- R10: `timeout_cycles` is sampled only when the countdown is loaded, so changing it during a window leaves that window's length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 1 | Merged interrupt event, one pulse per event |
| clr_strobe | input | 1 | Acknowledge from the host register write |
| timeout_cycles | input | CNT_W | Countdown reload value, in clocks |
| irq_req | output | 1 | Shared interrupt request line, active high |

## Verification
The assertions check every transition taken from each state on every clock, with the priority of an event over a clear. They also check the reload of the countdown from `timeout_cycles` and its decrement by one on each clock in which the state is held. The length of a whole window, the observed low gap before a re-raise and the absence of any spurious re-raise after a clear can only be measured in the bench's scenarios. Those scenarios sweep the reload value, the cycle at which a clear arrives, the cycle at which a second event arrives and the cycle of a retrigger, as well as same-cycle event and clear.

// File: rtl/irq_requeue_pkg.sv
package irq_requeue_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_QUEUED = 2'd2
    } irqq_state_e;

    typedef struct packed {
        logic load;
        logic dec;
    } irqq_timer_cmd_t;

endpackage

// File: rtl/irqq_timer.sv
module irqq_timer #(
    parameter int CNT_W = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  irq_requeue_pkg::irqq_timer_cmd_t cmd,
    input  logic [CNT_W-1:0]                 reload,
    output logic [CNT_W-1:0]                 count,
    output logic                             expired
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (cmd.load) begin
            count <= reload;
        end else if (cmd.dec) begin
            count <= count - ONE;
        end
    end

    assign expired = (count == '0);
endmodule

// File: rtl/irqq_fsm.sv
module irqq_fsm (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             evt,
    input  logic                             clr,
    input  logic                             expired,
    output irq_requeue_pkg::irqq_state_e     state,
    output irq_requeue_pkg::irqq_state_e     state_nxt,
    output irq_requeue_pkg::irqq_timer_cmd_t tcmd
);
    import irq_requeue_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        tcmd      = '0;
        unique case (state)
            ST_IDLE: begin
                if (evt) begin
                    state_nxt = ST_WAIT;
                    tcmd.load = 1'b1;
                end
            end
            ST_WAIT: begin
                if (evt) begin
                    state_nxt = ST_QUEUED;
                    tcmd.load = 1'b1;
                end else if (clr || expired) begin
                    state_nxt = ST_IDLE;
                end else begin
                    tcmd.dec = 1'b1;
                end
            end
            ST_QUEUED: begin
                if (evt) begin
                    tcmd.load = 1'b1;
                end else if (expired) begin
                    state_nxt = ST_WAIT;
                    tcmd.load = 1'b1;
                end else begin
                    tcmd.dec = 1'b1;
                end
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/irqq_out.sv
module irqq_out (
    input  logic                         clk,
    input  logic                         rst,
    input  irq_requeue_pkg::irqq_state_e state_nxt,
    output logic                         irq
);
    import irq_requeue_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= (state_nxt == ST_WAIT);
        end
    end
endmodule

// File: rtl/irq_requeue_top.sv
module irq_requeue_top #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_pulse,
    input  logic             clr_strobe,
    input  logic [CNT_W-1:0] timeout_cycles,
    output logic             irq_req
);
    import irq_requeue_pkg::*;

    irqq_state_e     cur_state;
    irqq_state_e     nxt_state;
    irqq_timer_cmd_t tcmd;
    logic [CNT_W-1:0] cnt;
    logic            cnt_zero;

    irqq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt_pulse),
        .clr      (clr_strobe),
        .expired  (cnt_zero),
        .state    (cur_state),
        .state_nxt(nxt_state),
        .tcmd     (tcmd)
    );

    irqq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .cmd    (tcmd),
        .reload (timeout_cycles),
        .count  (cnt),
        .expired(cnt_zero)
    );

    irqq_out u_out (
        .clk      (clk),
        .rst      (rst),
        .state_nxt(nxt_state),
        .irq      (irq_req)
    );
endmodule

// File: rtl/irq_requeue_chk.sv
module irq_requeue_chk #(
    parameter int CNT_W = 8
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         evt,
    input logic                         clr,
    input logic [CNT_W-1:0]             tmo,
    input logic                         irq,
    input irq_requeue_pkg::irqq_state_e state,
    input logic [CNT_W-1:0]             cnt
);
    import irq_requeue_pkg::*;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!irq && state == ST_IDLE));

    a_r2_idle_to_wait: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && evt) |=> (irq && state == ST_WAIT));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !evt) |=> (!irq && state == ST_IDLE));

    a_r3_wait_expiry: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !evt && !clr && cnt == '0) |=> (!irq && state == ST_IDLE));

    a_r4_wait_clear: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && clr && !evt) |=> (!irq && state == ST_IDLE));

    a_r5_r8_wait_to_queued: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && evt) |=> (!irq && state == ST_QUEUED && cnt == $past(tmo)));

    a_r6_queued_reraise: assert property (@(posedge clk) disable iff (rst)
        (state == ST_QUEUED && !evt && cnt == '0) |=> (irq && state == ST_WAIT && cnt == $past(tmo)));

    a_r7_queued_retrigger: assert property (@(posedge clk) disable iff (rst)
        (state == ST_QUEUED && evt) |=> (!irq && state == ST_QUEUED && cnt == $past(tmo)));

    a_r10_wait_countdown: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && !evt && !clr && cnt != '0) |=> (irq && cnt == $past(cnt) - 1'b1));

    a_r10_queued_countdown: assert property (@(posedge clk) disable iff (rst)
        (state == ST_QUEUED && !evt && cnt != '0) |=> (!irq && state == ST_QUEUED && cnt == $past(cnt) - 1'b1));
endmodule

bind irq_requeue_top irq_requeue_chk #(.CNT_W(CNT_W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .evt  (evt_pulse),
    .clr  (clr_strobe),
    .tmo  (timeout_cycles),
    .irq  (irq_req),
    .state(cur_state),
    .cnt  (cnt)
);

// File: tb/irq_requeue_top_test.sv
module irq_requeue_top_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       evt = 1'b0;
    logic       clr = 1'b0;
    logic [7:0] tmo = 8'd3;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    irq_requeue_top #(.CNT_W(8)) uut (
        .clk           (clk),
        .rst           (rst),
        .evt_pulse     (evt),
        .clr_strobe    (clr),
        .timeout_cycles(tmo),
        .irq_req       (irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic e, input logic c);
        evt = e;
        clr = c;
        @(negedge clk);
        evt = 1'b0;
        clr = 1'b0;
    endtask

    task automatic run_len(input logic lvl, input int cap, output int n);
        n = 0;
        while (irq === lvl && n < cap) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1 reset value", int'(irq), 0);
        rst = 1'b0;
        @(negedge clk);

        // R2 and R3: window length swept over reload values
        for (int t = 0; t < 8; t++) begin
            tmo = 8'(t);
            step(1'b1, 1'b0);
            chk("R2 raise after event", int'(irq), 1);
            run_len(1'b1, 40, n);
            chk("R3 window length", n, t + 1);
            run_len(1'b0, 6, n);
            chk("R3 stays low after expiry", n, 6);
        end

        // R4: clear at every position of the window
        tmo = 8'd6;
        for (int k = 0; k <= 6; k++) begin
            step(1'b1, 1'b0);
            for (int j = 0; j < k; j++) step(1'b0, 1'b0);
            chk("R4 high before clear", int'(irq), 1);
            step(1'b0, 1'b1);
            chk("R4 low after clear", int'(irq), 0);
            run_len(1'b0, 12, n);
            chk("R4 no re-raise", n, 12);
        end

        // R5 and R6: second event at every position, then re-raise
        tmo = 8'd4;
        for (int k = 0; k <= 4; k++) begin
            step(1'b1, 1'b0);
            for (int j = 0; j < k; j++) step(1'b0, 1'b0);
            step(1'b1, 1'b0);
            chk("R5 low after event in wait", int'(irq), 0);
            run_len(1'b0, 40, n);
            chk("R6 queued gap", n, 5);
            run_len(1'b1, 40, n);
            chk("R6 re-raised window", n, 5);
            run_len(1'b0, 8, n);
            chk("R6 idle after window", n, 8);
        end

        // R7: retrigger at every position of the queued gap
        tmo = 8'd3;
        for (int m = 0; m <= 3; m++) begin
            step(1'b1, 1'b0);
            step(1'b1, 1'b0);
            for (int j = 0; j < m; j++) step(1'b0, 1'b0);
            step(1'b1, 1'b0);
            run_len(1'b0, 40, n);
            chk("R7 gap after retrigger", n, 4);
            run_len(1'b1, 40, n);
            chk("R7 window after retrigger", n, 4);
            run_len(1'b0, 6, n);
            chk("R7 idle after window", n, 6);
        end

        // R8: event and clear together
        step(1'b1, 1'b1);
        chk("R8 idle event beats clear", int'(irq), 1);
        step(1'b1, 1'b1);
        chk("R8 wait event beats clear", int'(irq), 0);
        run_len(1'b0, 40, n);
        chk("R8 queued gap", n, 4);
        run_len(1'b1, 40, n);
        chk("R8 re-raised window", n, 4);

        // R9: clear ignored in idle and in queued
        run_len(1'b0, 3, n);
        step(1'b0, 1'b1);
        run_len(1'b0, 10, n);
        chk("R9 clear in idle", n, 10);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b1);
        run_len(1'b0, 40, n);
        chk("R9 clear in queued gap", n, 2);
        run_len(1'b1, 40, n);
        chk("R9 re-raise after ignored clear", n, 4);
        run_len(1'b0, 6, n);

        // R10: reload sampled only at load
        tmo = 8'd5;
        step(1'b1, 1'b0);
        tmo = 8'd1;
        run_len(1'b1, 40, n);
        chk("R10 window keeps loaded value", n, 6);
        step(1'b1, 1'b0);
        run_len(1'b1, 40, n);
        chk("R10 next window uses new value", n, 2);
        run_len(1'b0, 4, n);

        // R1: reset during service
        tmo = 8'd5;
        step(1'b1, 1'b0);
        chk("R1 high before reset", int'(irq), 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 reset mid-service", int'(irq), 0);
        rst = 1'b0;
        run_len(1'b0, 10, n);
        chk("R1 idle after reset", n, 10);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule